// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter

This block is a 16-bit down-counting timer that raises an interrupt each time its count runs out. Software programs it through a small synchronous register port with three words: a control and status word, a modulus word that holds the reload value, and a read-only word that returns the live count. The count steps once every 2^(P+1) system clocks. P is a 4-bit power-of-two prescaler code, so the step divides the clock by 2 up to 65536.

On each step the count decrements by one. When a step finds the count at zero, the timer expires: it sets a sticky interrupt flag and reloads. In modulus mode the reload value is the modulus word. In free-run mode it is the full-scale value 0xFFFF. The interrupt line is the flag gated by an enable bit. The flag is cleared by writing a one to its bit.

Control writes fall into two kinds. A write that changes only the interrupt enable or the flag leaves the running divider alone. Any other change restarts the divider from zero. Two bits, the debug and low-power bits, are stored and read back but have no effect.

Top module: `tick_timer_top`

## Requirements
- R1: After a synchronous reset, all three readable words read 0, the interrupt line is low and the count does not move.
- R2: While enable (control bit 0) is 1, the count changes once every 2^(P+1) clocks, where P is control bits 11:8. A step on a nonzero count decrements it by one. While enable is 0 the count holds and the divider stays cleared, so the first step comes a full 2^(P+1) clocks after enabling.
- R3: A step that finds the count at 0 sets the flag (control bit 2) whether or not interrupts are enabled. When reload mode (control bit 1) is 1, the count takes the modulus value.
- R4: When reload mode is 0, a step that finds the count at 0 loads 0xFFFF, and counting continues from there.
- R5: The interrupt output is high exactly when interrupt enable (control bit 3) and the flag are both 1.
- R6: A control write with bit 2 set clears the flag. A control write with bit 2 clear leaves the flag as it is. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: A control write that differs from the stored value only in bits 2 and 3 does not disturb the divider's phase, and the steps keep their spacing.
- R8: A control write that changes any other stored field restarts the divider from zero and applies the new prescaler and mode. No step happens in the write cycle. The count keeps its value, and counting resumes only if enable is 1.
- R9: A modulus write when overwrite (control bit 4) is 1 loads the count with the written value on the next clock edge, and this takes priority over a step in the same cycle. When overwrite is 0, the count is untouched and the new modulus is used at the next reload.
- R10: The word at offset 0 is control/status, offset 2 is modulus, and offset 4 is the count. Writes to offset 4 and to unused offsets are ignored, and unused offsets read 0. Control bits 5 and 6 are stored and read back, and bits 7 and 15:12 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_addr | input | 3 | Word offset (0 control, 2 modulus, 4 count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the collisions on a single edge: a clearing write that lands in the same cycle as an expiry, a modulus overwrite in the same cycle as a step, and a control write in the middle of a divider period. Whether the divider kept its phase in that last case shows only in the spacing of later steps. The bench reaches these with short modulus values and the smallest prescaler codes, which make expiries frequent. It then issues long runs of random writes to all offsets while a behavioural model predicts the read data and the interrupt line on every clock. Directed sections cover the largest prescaler code, rollover in free-run mode and the write-only offset.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 1 << PRE_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MOD   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             rld;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [PRE_W-1:0] pre,
                                          input logic [6:0] low);
        ctrl_t c;
        c.pre  = pre;
        c.doze = low[6];
        c.dbg  = low[5];
        c.ovw  = low[4];
        c.ie   = low[3];
        c.rld  = low[1];
        c.en   = low[0];
        return c;
    endfunction

    function automatic logic cfg_differs(input ctrl_t a, input ctrl_t b);
        return (a.pre != b.pre) || (a.doze != b.doze) || (a.dbg != b.dbg) ||
               (a.ovw != b.ovw) || (a.rld != b.rld) || (a.en != b.en);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_timer_pkg::*;
#(
    parameter int P_W = PRE_W,
    localparam int D_W = 1 << P_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_i,
    input  logic           restart_i,
    input  logic [P_W-1:0] pre_i,
    output logic           tick_o
);
    logic [D_W-1:0] ps_q;
    logic [D_W-1:0] limit;
    logic           hit;

    always_comb begin
        limit = {D_W{1'b1}} >> (D_W - 1 - int'(pre_i));
        hit   = (ps_q == limit);
    end

    assign tick_o = run_i && !restart_i && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
        end else if (!run_i || restart_i || hit) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_q + 1'b1;
        end
    end

    assert_ps_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (ps_q == '0));
    assert_ps_restart_R8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (ps_q == '0));
endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_timer_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  logic           load_i,
    input  logic [C_W-1:0] load_val_i,
    input  logic           reload_en_i,
    input  logic [C_W-1:0] modulus_i,
    output logic [C_W-1:0] count_o,
    output logic           expire_o
);
    logic [C_W-1:0] count_q;
    logic [C_W-1:0] reload_val;

    assign reload_val = reload_en_i ? modulus_i : {C_W{1'b1}};
    assign expire_o   = tick_i && (count_q == '0);
    assign count_o    = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (tick_i) begin
            count_q <= (count_q == '0) ? reload_val : count_q - 1'b1;
        end
    end

    assert_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(count_q));
    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && count_q == '0 && reload_en_i) |=> (count_q == $past(modulus_i)));
    assert_rollover_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && count_q == '0 && !reload_en_i) |=> (count_q == {C_W{1'b1}}));
    assert_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_q == $past(load_val_i)));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [C_W-1:0]    wdata_i,
    input  logic              expire_i,
    input  logic [C_W-1:0]    count_i,
    output ctrl_t             ctrl_o,
    output logic [C_W-1:0]    modulus_o,
    output logic              restart_o,
    output logic              load_o,
    output logic [C_W-1:0]    rdata_o,
    output logic              irq_o
);
    ctrl_t          ctrl_q;
    ctrl_t          ctrl_new;
    logic [C_W-1:0] mod_q;
    logic           flag_q;
    logic           ctrl_wr;
    logic           mod_wr;
    logic [11:0]    ctrl_word;
    logic           unused_bits;

    assign unused_bits = ^{wdata_i[C_W-1:12], wdata_i[7]};

    assign ctrl_wr   = wr_i && (addr_i == OFS_CTRL);
    assign mod_wr    = wr_i && (addr_i == OFS_MOD);
    assign ctrl_new  = unpack_ctrl(wdata_i[11:8], wdata_i[6:0]);
    assign restart_o = ctrl_wr && cfg_differs(ctrl_new, ctrl_q);
    assign load_o    = mod_wr && ctrl_q.ovw;
    assign ctrl_o    = ctrl_q;
    assign modulus_o = mod_q;
    assign irq_o     = ctrl_q.ie && flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mod_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_new;
            end
            if (mod_wr) begin
                mod_q <= wdata_i;
            end
            if (expire_i) begin
                flag_q <= 1'b1;
            end else if (ctrl_wr && wdata_i[2]) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign ctrl_word = {ctrl_q.pre, 1'b0, ctrl_q.doze, ctrl_q.dbg, ctrl_q.ovw,
                        ctrl_q.ie, flag_q, ctrl_q.rld, ctrl_q.en};

    always_comb begin
        case (addr_i)
            OFS_CTRL:  rdata_o = {{(C_W-12){1'b0}}, ctrl_word};
            OFS_MOD:   rdata_o = mod_q;
            OFS_COUNT: rdata_o = count_i;
            default:   rdata_o = '0;
        endcase
    end

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> flag_q);
    assert_flag_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(expire_i));
    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata_i[2] && !expire_i) |=> !flag_q);
    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(expire_i) || $past(ctrl_wr)));
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
    import tick_timer_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [C_W-1:0]    reg_wdata,
    output logic [C_W-1:0]    reg_rdata,
    output logic              irq_o
);
    ctrl_t          ctrl;
    logic [C_W-1:0] modulus;
    logic [C_W-1:0] count;
    logic           restart;
    logic           load;
    logic           tick;
    logic           expire;

    tick_regs #(.C_W(C_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .expire_i  (expire),
        .count_i   (count),
        .ctrl_o    (ctrl),
        .modulus_o (modulus),
        .restart_o (restart),
        .load_o    (load),
        .rdata_o   (reg_rdata),
        .irq_o     (irq_o)
    );

    tick_prescaler #(.P_W(PRE_W)) pre_i (
        .clk       (clk),
        .rst       (rst),
        .run_i     (ctrl.en),
        .restart_i (restart),
        .pre_i     (ctrl.pre),
        .tick_o    (tick)
    );

    tick_counter #(.C_W(C_W)) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .load_i      (load),
        .load_val_i  (reg_wdata),
        .reload_en_i (ctrl.rld),
        .modulus_i   (modulus),
        .count_o     (count),
        .expire_o    (expire)
    );

    assert_restart_no_step_R8: assert property (@(posedge clk) disable iff (rst)
        (restart && !load) |=> $stable(count));
endmodule

// File: tb/tick_timer_top_tb.sv
`timescale 1ns/100ps
module tick_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd4;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 0;

    int m_ctrl, m_mod, m_cnt, m_ps, m_flag;

    always #2.5 clk = ~clk;

    tick_timer_top dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Behavioural reference, stepped on each rising edge with the inputs held stable.
    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_mod = 0; m_cnt = 0; m_ps = 0; m_flag = 0;
        end else begin
            bit cw, mw, full, tk, ex;
            int div;
            cw   = reg_wr && reg_addr == 3'd0;
            mw   = reg_wr && reg_addr == 3'd2;
            full = cw && (((m_ctrl ^ int'(reg_wdata)) & 'h0F73) != 0);
            div  = 1 << (((m_ctrl >> 8) & 15) + 1);
            tk   = 0;
            if ((m_ctrl & 1) == 0 || full) m_ps = 0;
            else if (m_ps == div - 1) begin tk = 1; m_ps = 0; end
            else m_ps++;
            ex = tk && m_cnt == 0;
            if (mw && (m_ctrl & 'h10) != 0) m_cnt = int'(reg_wdata);
            else if (tk) m_cnt = (m_cnt == 0) ? (((m_ctrl & 2) != 0) ? m_mod : 'hFFFF) : m_cnt - 1;
            if (ex) m_flag = 1;
            else if (cw && reg_wdata[2]) m_flag = 0;
            if (mw) m_mod = int'(reg_wdata);
            if (cw) m_ctrl = int'(reg_wdata) & 'h0F7B;
        end
    end

    function automatic int model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl | (m_flag << 2);
            3'd2: return m_mod;
            3'd4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "rdata", int'(reg_rdata), model_read(reg_addr));
            check("R5", "irq", int'(irq_o), (((m_ctrl >> 3) & 1) & m_flag));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            reg_wr = 1'b0; reg_addr = 3'd4;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_addr = 3'd4;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_addr = a;
        @(negedge clk); #1;
        reg_addr = 3'd4;
    endtask

    initial begin
        idle(3);
        @(negedge clk); #1; rst = 1'b0;
        // R1: reset values on every offset, count frozen
        cur_req = "R1";
        rd(3'd0); rd(3'd2); rd(3'd4);
        idle(10);

        // R10: map, write-only offset ignored, stored-only bits, reserved bits read 0
        cur_req = "R10";
        wr(3'd2, 16'd5);
        wr(3'd4, 16'h1234);
        wr(3'd6, 16'hBEEF);
        rd(3'd6); rd(3'd4);
        wr(3'd0, 16'hF3E0);
        rd(3'd0);
        idle(20);
        wr(3'd0, 16'h0000);
        rd(3'd0);

        // R2 / R3: smallest prescaler, modulus reload, interrupts enabled
        cur_req = "R3";
        wr(3'd0, 16'h000B);
        idle(60);
        rd(3'd0);

        // R6: write 0 to flag bit keeps it, write 1 clears it
        cur_req = "R6";
        wr(3'd0, 16'h000B);
        rd(3'd0);
        wr(3'd0, 16'h000F);
        rd(3'd0);
        idle(7);
        for (int k = 0; k < 12; k++) begin
            wr(3'd0, 16'h000F);
        end

        // R7: interrupt-only writes during counting at prescaler code 2
        cur_req = "R7";
        wr(3'd0, 16'h0203);
        idle(5);
        for (int k = 0; k < 20; k++) begin
            wr(3'd0, (k % 2 == 0) ? 16'h020F : 16'h0207);
            idle(k % 5);
        end

        // R8: configuration change mid-period restarts the divider
        cur_req = "R8";
        for (int k = 0; k < 8; k++) begin
            idle(3 + k);
            wr(3'd0, (k % 2 == 0) ? 16'h0103 : 16'h0203);
        end
        wr(3'd0, 16'h0102);
        idle(30);

        // R4: free-run rollover to full scale
        cur_req = "R4";
        wr(3'd0, 16'h0011);
        wr(3'd2, 16'd2);
        idle(20);
        wr(3'd0, 16'h0009);
        idle(40);

        // R9: overwrite on and off
        cur_req = "R9";
        wr(3'd0, 16'h001B);
        for (int k = 0; k < 10; k++) begin
            idle(k);
            wr(3'd2, 16'(k + 3));
        end
        wr(3'd0, 16'h000B);
        wr(3'd2, 16'd9);
        idle(40);

        // R2: largest prescaler code, one full period
        cur_req = "R2";
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h0F0B);
        idle(132000);
        wr(3'd0, 16'h0F0A);
        idle(20);

        // Mixed random traffic over all offsets, small prescaler codes
        cur_req = "R9";
        for (int k = 0; k < 3000; k++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 3) wr(3'd0, 16'($urandom) & 16'h01FF | 16'h0001);
            else if (sel < 5) wr(3'd2, 16'($urandom_range(0, 6)));
            else if (sel == 5) wr(3'($urandom_range(0, 7)), 16'($urandom));
            else if (sel == 6) rd(3'($urandom_range(0, 7)));
            else idle(int'($urandom_range(1, 6)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule